// File: doc/BRIEF.md
# UART Modem Control Register Logic

This block keeps the 8-bit modem control register of one UART channel and turns its bits into the control signals that the rest of the channel uses. A CPU writes the register through a simple write strobe and data byte, and can read it back at any time. The block decides whether the channel's interrupt pin is actively driven or left in three-state. It drives the active-low auxiliary output used during internal loopback. It produces the loopback and infrared routing selects and the resume-on-any-character enable. It also makes a baud clock enable from a prescaler that passes the input clock through or divides it by four.

The three upper bits belong to the enhanced feature set. While the enhanced enable input is low, they cannot be written and they have no effect on any output. The interrupt pin drive depends on bit 3, on an external interrupt-select pin and on the bus style (16-style or 68-style) of the host interface.

Top module: `uart_mctl`

## Requirements
- R1: After synchronous reset the register reads 0x00. With `irq_sel` low and 16-style bus mode, `irq_oe` is 0, `aux2_n` is 1, and `loop_sel`, `ir_sel` and `resume_any` are 0.
- R2: A write (`wr_en` high on a rising edge) always stores `wr_data[4:0]` into bits 4..0. `rd_data` returns all 8 stored bits from the cycle after the edge.
- R3: While `enh_en` is 0, a write leaves bits 7..5 at their previous values. While `enh_en` is 1, a write stores them from `wr_data[7:5]`.
- R4: In 16-style mode (`bus_68` = 0) with `irq_sel` low, `irq_oe` equals bit 3: 0 means three-state and 1 means driven.
- R5: While `irq_sel` is high, `irq_oe` is 1 whatever bit 3 holds.
- R6: In 68-style mode (`bus_68` = 1), `irq_oe` is 1. The host must keep `irq_sel` low in this mode.
- R7: `loop_sel` equals bit 4. While bit 4 is 1, `aux2_n` is the inverse of bit 3. While bit 4 is 0, `aux2_n` is held at 1.
- R8: `resume_any` is bit 5 AND `enh_en`. `ir_sel` (route TX/RX through the infrared codec, whose transmit line idles low) is bit 6 AND `enh_en`.
- R9: While bit 7 AND `enh_en` (the effective quarter select) is 0, `baud_tick` is 1 in every cycle.
- R10: While the effective quarter select is 1, `baud_tick` is high for one cycle in every four. Each change of the effective select restarts the count. The first pulse follows the fourth rising edge after the select turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the prescaler input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| enh_en | input | 1 | Enhanced feature enable (unlocks bits 7..5) |
| bus_68 | input | 1 | Bus style: 0 = 16-style, 1 = 68-style |
| irq_sel | input | 1 | Interrupt-select pin |
| irq_oe | output | 1 | Interrupt pin output enable (0 = three-state) |
| aux2_n | output | 1 | Active-low auxiliary output 2 |
| loop_sel | output | 1 | Internal loopback select |
| ir_sel | output | 1 | Infrared routing select |
| resume_any | output | 1 | Any received character resumes transmission |
| baud_tick | output | 1 | Clock enable toward the baud generator |

## Verification
A vector table walks writes and pin settings that separate the three sources of interrupt drive: bit 3 alone, the select pin overriding it, and the 68-style bus forcing it. The same table writes all ones and then partial values with the enhanced enable low and high, which shows whether bits 7..5 were locked, stored or merely gated. Loopback is entered with bit 3 at both values, so that an auxiliary output stuck at one level is caught. Directed prescaler runs count pulses and the position of the first pulse after a register write and after an enhanced-enable toggle, which tells divide-by-one, divide-by-four and a missing restart apart.

// File: rtl/mctl_pkg.sv
package mctl_pkg;

    localparam int REG_W    = 8;
    localparam int PRE_DIV  = 4;
    localparam logic [REG_W-1:0] ENH_MASK = 8'hE0;

    typedef struct packed {
        logic clk_quarter;
        logic ir_route;
        logic resume_any;
        logic loop_en;
        logic irq_gate;
        logic aux1;
        logic req_send;
        logic term_ready;
    } mctl_reg_t;

    typedef enum logic {
        BUS_16 = 1'b0,
        BUS_68 = 1'b1
    } bus_style_e;

    typedef struct packed {
        logic irq_oe;
        logic aux2_n;
        logic loop_sel;
        logic ir_sel;
        logic resume_any;
        logic quarter;
    } mctl_fx_t;

    function automatic mctl_reg_t merge_write(mctl_reg_t cur,
                                              logic [REG_W-1:0] wd,
                                              logic enh);
        logic [REG_W-1:0] keep;
        logic [REG_W-1:0] cur_b;
        keep  = enh ? '0 : ENH_MASK;
        cur_b = cur;
        return mctl_reg_t'((wd & ~keep) | (cur_b & keep));
    endfunction

endpackage

// File: rtl/mctl_regs.sv
module mctl_regs
    import mctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             enh_en,
    output mctl_reg_t        reg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (wr_en) begin
            reg_q <= merge_write(reg_q, wr_data, enh_en);
        end
    end

endmodule

// File: rtl/mctl_fx.sv
module mctl_fx
    import mctl_pkg::*;
(
    input  logic       irq_gate,
    input  logic       loop_en,
    input  logic       resume_bit,
    input  logic       ir_bit,
    input  logic       quarter_bit,
    input  logic       enh_en,
    input  bus_style_e bus_style,
    input  logic       irq_sel,
    output mctl_fx_t   fx
);

    always_comb begin
        fx = '0;
        unique case (bus_style)
            BUS_68:  fx.irq_oe = 1'b1;
            default: fx.irq_oe = irq_sel | irq_gate;
        endcase
        fx.loop_sel   = loop_en;
        fx.aux2_n     = loop_en ? ~irq_gate : 1'b1;
        fx.resume_any = resume_bit  & enh_en;
        fx.ir_sel     = ir_bit      & enh_en;
        fx.quarter    = quarter_bit & enh_en;
    end

endmodule

// File: rtl/mctl_prescale.sv
module mctl_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_div,
    output logic tick
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel_div;
            if (sel_div != sel_q) begin
                cnt <= '0;
            end else if (cnt == LAST) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign tick = sel_div ? (sel_q && (cnt == LAST)) : 1'b1;

endmodule

// File: rtl/uart_mctl.sv
module uart_mctl
    import mctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             enh_en,
    input  logic             bus_68,
    input  logic             irq_sel,
    output logic             irq_oe,
    output logic             aux2_n,
    output logic             loop_sel,
    output logic             ir_sel,
    output logic             resume_any,
    output logic             baud_tick
);

    mctl_reg_t reg_q;
    mctl_fx_t  fx;

    mctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .enh_en  (enh_en),
        .reg_q   (reg_q)
    );

    mctl_fx u_fx (
        .irq_gate    (reg_q.irq_gate),
        .loop_en     (reg_q.loop_en),
        .resume_bit  (reg_q.resume_any),
        .ir_bit      (reg_q.ir_route),
        .quarter_bit (reg_q.clk_quarter),
        .enh_en      (enh_en),
        .bus_style   (bus_style_e'(bus_68)),
        .irq_sel     (irq_sel),
        .fx          (fx)
    );

    mctl_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .sel_div (fx.quarter),
        .tick    (baud_tick)
    );

    assign rd_data    = reg_q;
    assign irq_oe     = fx.irq_oe;
    assign aux2_n     = fx.aux2_n;
    assign loop_sel   = fx.loop_sel;
    assign ir_sel     = fx.ir_sel;
    assign resume_any = fx.resume_any;

endmodule

// File: rtl/mctl_chk.sv
module mctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       enh_en,
    input logic       bus_68,
    input logic       irq_sel,
    input logic       irq_oe,
    input logic       aux2_n,
    input logic       loop_sel,
    input logic       ir_sel,
    input logic       resume_any,
    input logic       baud_tick
);

    logic eff_q;
    assign eff_q = rd_data[7] & enh_en;

    p_low_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[4:0] == $past(wr_data[4:0]));

    p_locked_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !enh_en) |=> rd_data[7:5] == $past(rd_data[7:5]));

    p_irq_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (!bus_68 && !irq_sel) |-> irq_oe == rd_data[3]);

    p_irq_forced_r5: assert property (@(posedge clk) disable iff (rst)
        irq_sel |-> irq_oe);

    p_irq_68_r6: assert property (@(posedge clk) disable iff (rst)
        bus_68 |-> irq_oe);

    p_aux_loop_r7: assert property (@(posedge clk) disable iff (rst)
        loop_sel |-> aux2_n == !rd_data[3]);

    p_aux_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !loop_sel |-> aux2_n);

    p_ir_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !enh_en |-> !ir_sel && !resume_any);

    p_div1_r9: assert property (@(posedge clk) disable iff (rst)
        !eff_q |-> baud_tick);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (eff_q && baud_tick) |=> (!baud_tick || !eff_q));

endmodule

bind uart_mctl mctl_chk u_chk (.*);

// File: tb/sim_uart_mctl.sv
`timescale 1ns/1ps
module sim_uart_mctl;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       enh_en;
    logic       bus_68;
    logic       irq_sel;
    logic       irq_oe;
    logic       aux2_n;
    logic       loop_sel;
    logic       ir_sel;
    logic       resume_any;
    logic       baud_tick;

    int n_total = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    uart_mctl u0 (.*);

    // {enh, bus_68, irq_sel, wr_en, wr_data, exp_rd, exp oe/aux2_n/loop/ir/resume}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {4'b0001, 8'h08, 8'h08, 5'b11000},
        {4'b0001, 8'hFF, 8'h1F, 5'b10100},
        {4'b0001, 8'h10, 8'h10, 5'b01100},
        {4'b0010, 8'h00, 8'h10, 5'b11100},
        {4'b1001, 8'h60, 8'h60, 5'b01011},
        {4'b0000, 8'h00, 8'h60, 5'b01000},
        {4'b0001, 8'h08, 8'h68, 5'b11000},
        {4'b0101, 8'h00, 8'h60, 5'b11000},
        {4'b1000, 8'h00, 8'h60, 5'b01011},
        {4'b1001, 8'h00, 8'h00, 5'b01000}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_ticks(input int len, output int count, output int first);
        count = 0;
        first = -1;
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (baud_tick) begin
                count++;
                if (first < 0) first = n;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int cnt;
        int first;
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        enh_en = 1'b0; bus_68 = 1'b0; irq_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 outputs", {3'b0, irq_oe, aux2_n, loop_sel, ir_sel, resume_any}, 8'h08);
        check("R9 tick after reset", {7'b0, baud_tick}, 8'h01);

        // Table: R2..R8
        for (int i = 0; i < NV; i++) begin
            {enh_en, bus_68, irq_sel, wr_en} = VEC[i][24:21];
            wr_data = VEC[i][20:13];
            @(negedge clk);
            check($sformatf("R2/R3 vec%0d rd_data", i), rd_data, VEC[i][12:5]);
            check($sformatf("R4-R8 vec%0d outputs", i),
                  {3'b0, irq_oe, aux2_n, loop_sel, ir_sel, resume_any},
                  {3'b0, VEC[i][4:0]});
            wr_en = 1'b0;
        end

        // R9: divide-by-one, effective select off
        enh_en = 1'b0; bus_68 = 1'b0; irq_sel = 1'b0;
        run_ticks(8, cnt, first);
        check("R9 div1 count", 8'(cnt), 8'd8);

        // R10: write bit 7 with enh on
        @(negedge clk);
        enh_en = 1'b1; wr_en = 1'b1; wr_data = 8'h80;
        run_ticks(16, cnt, first);
        check("R10 div4 count after write", 8'(cnt), 8'd3);
        check("R10 first pulse after write", 8'(first), 8'd4);
        check("R3 bit7 stored", rd_data, 8'h80);

        // R9/R10: enh off gates the select back to divide-by-one
        enh_en = 1'b0;
        run_ticks(8, cnt, first);
        check("R9 gated select count", 8'(cnt), 8'd8);

        // R10: enh on restarts the count
        enh_en = 1'b1;
        run_ticks(16, cnt, first);
        check("R10 first pulse after enh toggle", 8'(first), 8'd3);
        check("R10 div4 count after toggle", 8'(cnt), 8'd4);

        // R6 with bit 3 clear in 68-style mode
        bus_68 = 1'b1; wr_en = 1'b1; wr_data = 8'h80;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 68-style drive", {7'b0, irq_oe}, 8'h01);
        bus_68 = 1'b0;
        @(negedge clk);
        check("R4 three-state with bit3 clear", {7'b0, irq_oe}, 8'h00);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule